// File: doc/BRIEF.md
# Delayed-Jump Next-PC Sequencer with Instruction-Set Mode Switching

This block owns the fetch address and the instruction-set mode bit of a processor that can run either full-width 32-bit instructions or compact 16-bit instructions. Every cycle it is shown the decoded control-flow event of the instruction at the current fetch address. The event is an absolute jump-and-link, a jump-and-link that also swaps the instruction set, a register jump, or a conditional branch whose outcome has already been resolved. When the fetch-advance input is high, the block steps to the next address.

Jumps always keep one delay slot. The instruction right after a jump still executes, and the target together with any new mode is parked in a pending register until that slot retires. The link-register write is produced while the delay slot retires, so it can use the length of the slot. Branches have no delay slot: a taken branch redirects fetch at once. Bit 0 of link values and register targets carries the instruction-set mode. The block flags an address error whenever it fetches a full-width instruction from an address that is not word aligned.

Top module: `npc_seq`

## Requirements
- R1: While `rst_i` is high, the block loads `pc_o` = `RESET_VEC` (default 0x0000_1000), selects 32-bit mode (`isa16_o` = 0) and clears the pending jump. `link_we_o` and `addr_err_o` are then 0.
- R2: A non-jump, non-taken-branch instruction with `adv_i` high moves `pc_o` to `pc_o` + 4 when `len16_i` = 0 and to `pc_o` + 2 when `len16_i` = 1. The mode is left unchanged.
- R3: With `adv_i` low, `pc_o`, `isa16_o` and the pending jump keep their values and `link_we_o` stays 0, whatever the event inputs are.
- R4: An absolute jump (`jal_i` or `jalx_i`) at address P first advances to the delay slot D = P + length. After the slot retires, `pc_o` = {D[31:28], `jtgt_i`, 2'b00}. For `jal_i` the mode is unchanged.
- R5: The link write for an absolute jump happens in the cycle the delay slot retires. `link_we_o` = 1 and `link_o` = (D + length of D) with bit 0 set to the mode that was in force at the jump.
- R6: For `jalx_i`, `isa16_o` keeps its old value through the delay slot and inverts when the slot retires. Bit 0 of `link_o` holds the old mode.
- R7: A register jump (`jr_i`) keeps one delay slot and then sets the mode to `rs_i[0]` (1 = compact 16-bit). The new `pc_o` is `rs_i` with bit 0 cleared in compact mode and `rs_i` unchanged in 32-bit mode.
- R8: A branch (`br_i`) with `br_taken_i` = 1 moves `pc_o` to `br_tgt_i` on that same advance, with no delay slot. With `br_taken_i` = 0 it advances like R2.
- R9: `addr_err_o` is 1 exactly when the mode is 32-bit and `pc_o[1:0]` is not 00.
- R10: Control-flow events presented while a delay slot retires are ignored. Fetch proceeds to the pending target, and no new delay slot or link write results.
- R11: Register jumps and branches never assert `link_we_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| adv_i | input | 1 | Current instruction retires, fetch steps on |
| len16_i | input | 1 | Current instruction is 16 bits long (else 32) |
| jal_i | input | 1 | Absolute jump-and-link |
| jalx_i | input | 1 | Absolute jump-and-link with mode swap |
| jr_i | input | 1 | Jump to register operand |
| br_i | input | 1 | Conditional branch |
| br_taken_i | input | 1 | Resolved branch outcome |
| br_tgt_i | input | 32 | Branch target address |
| jtgt_i | input | 26 | Absolute jump target field |
| rs_i | input | 32 | Register operand for a register jump |
| pc_o | output | 32 | Current fetch address |
| isa16_o | output | 1 | Mode: 1 = compact 16-bit, 0 = 32-bit |
| link_we_o | output | 1 | Link register write enable |
| link_o | output | 32 | Link register write value |
| addr_err_o | output | 1 | Fetch address error |

## Verification
The assertions assume that at most one of the four event inputs is high in a cycle, and that branch targets are halfword aligned, so compact-mode fetch addresses stay even. The directed tasks drive a single event per step. Every branch target they use is even, and odd values appear only on `rs_i`, where the block itself must clear bit 0. Delay slots in the bench are plain instructions, except in the task that deliberately places a jump inside a slot to show that it is ignored.

// File: rtl/npc_pkg.sv
package npc_pkg;

   typedef enum logic {
      ISA_W32 = 1'b0,
      ISA_C16 = 1'b1
   } isa_e;

   typedef enum logic [1:0] {
      FLOW_SEQ  = 2'd0,
      FLOW_BR   = 2'd1,
      FLOW_PEND = 2'd2
   } flow_e;

endpackage

// File: rtl/npc_jump_calc.sv
module npc_jump_calc
   import npc_pkg::*;
#(
   parameter int AW = 32,
   parameter int TW = 26,
   localparam int HI_W = AW - TW - 2
) (
   input  logic [HI_W-1:0] slot_hi_i,
   input  logic [TW-1:0]   jtgt_i,
   input  logic [AW-1:0]   rs_i,
   output logic [AW-1:0]   abs_tgt_o,
   output logic [AW-1:0]   reg_tgt_o,
   output isa_e            reg_mode_o
);

   generate
      if (HI_W < 1) begin : g_bad_width
         $error("npc_jump_calc: address width must exceed target field plus two");
      end
   endgenerate

   always_comb begin
      abs_tgt_o = {slot_hi_i, jtgt_i, 2'b00};
   end

   always_comb begin
      reg_mode_o = isa_e'(rs_i[0]);
      if (rs_i[0]) begin
         reg_tgt_o = {rs_i[AW-1:1], 1'b0};
      end else begin
         reg_tgt_o = rs_i;
      end
   end

endmodule

// File: rtl/npc_pend_reg.sv
module npc_pend_reg
   import npc_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic          clk_i,
   input  logic          rst_i,
   input  logic          load_i,
   input  logic          clr_i,
   input  logic [AW-1:0] tgt_i,
   input  isa_e          mode_i,
   input  logic          link_i,
   input  isa_e          lmode_i,
   output logic          vld_o,
   output logic [AW-1:0] tgt_o,
   output isa_e          mode_o,
   output logic          link_o,
   output isa_e          lmode_o
);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         vld_o   <= 1'b0;
         tgt_o   <= '0;
         mode_o  <= ISA_W32;
         link_o  <= 1'b0;
         lmode_o <= ISA_W32;
      end else if (load_i) begin
         vld_o   <= 1'b1;
         tgt_o   <= tgt_i;
         mode_o  <= mode_i;
         link_o  <= link_i;
         lmode_o <= lmode_i;
      end else if (clr_i) begin
         vld_o   <= 1'b0;
         link_o  <= 1'b0;
      end
   end

   // R10: a jump is never parked on top of one still waiting
   p_no_overlap_r10: assert property (@(posedge clk_i) disable iff (rst_i)
      load_i |-> !vld_o);

   // R3: the parked jump survives a stalled cycle
   p_pend_hold_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      (!load_i && !clr_i) |=> $stable(vld_o) && $stable(tgt_o));

endmodule

// File: rtl/npc_seq.sv
module npc_seq
   import npc_pkg::*;
#(
   parameter int          AW        = 32,
   parameter int          TW        = 26,
   parameter logic [31:0] RESET_VEC = 32'h0000_1000
) (
   input  logic          clk_i,
   input  logic          rst_i,
   input  logic          adv_i,
   input  logic          len16_i,
   input  logic          jal_i,
   input  logic          jalx_i,
   input  logic          jr_i,
   input  logic          br_i,
   input  logic          br_taken_i,
   input  logic [AW-1:0] br_tgt_i,
   input  logic [TW-1:0] jtgt_i,
   input  logic [AW-1:0] rs_i,
   output logic [AW-1:0] pc_o,
   output logic          isa16_o,
   output logic          link_we_o,
   output logic [AW-1:0] link_o,
   output logic          addr_err_o
);

   localparam int          HI_W  = AW - TW - 2;
   localparam logic [AW-1:0] INC16 = AW'(2);
   localparam logic [AW-1:0] INC32 = AW'(4);
   localparam logic [AW-1:0] RVEC  = RESET_VEC[AW-1:0];

   generate
      if (AW > 32) begin : g_bad_aw
         $error("npc_seq: address width above 32 not supported by reset vector");
      end
      if (RESET_VEC[1:0] != 2'b00) begin : g_bad_rvec
         $error("npc_seq: reset vector must be word aligned");
      end
   endgenerate

   logic [AW-1:0] pc_q;
   isa_e          mode_q;
   logic [AW-1:0] seq_addr;
   logic [AW-1:0] abs_tgt;
   logic [AW-1:0] reg_tgt;
   isa_e          reg_mode;
   logic          pend_vld;
   logic [AW-1:0] pend_tgt;
   isa_e          pend_mode;
   logic          pend_link;
   isa_e          pend_lmode;
   logic          any_jump;
   logic          take_jump;
   logic          consume;
   logic          br_go;
   flow_e         flow;
   logic [AW-1:0] pc_next;
   logic [AW-1:0] jump_tgt;
   isa_e          jump_mode;

   always_comb begin
      seq_addr = pc_q + (len16_i ? INC16 : INC32);
   end

   npc_jump_calc #(.AW(AW), .TW(TW)) calc_i (
      .slot_hi_i  (seq_addr[AW-1 -: HI_W]),
      .jtgt_i     (jtgt_i),
      .rs_i       (rs_i),
      .abs_tgt_o  (abs_tgt),
      .reg_tgt_o  (reg_tgt),
      .reg_mode_o (reg_mode)
   );

   always_comb begin
      any_jump  = jal_i | jalx_i | jr_i;
      take_jump = adv_i & ~pend_vld & any_jump;
      consume   = adv_i & pend_vld;
      br_go     = adv_i & ~pend_vld & br_i & br_taken_i;
   end

   always_comb begin
      if (jr_i) begin
         jump_tgt  = reg_tgt;
         jump_mode = reg_mode;
      end else begin
         jump_tgt  = abs_tgt;
         jump_mode = jalx_i ? isa_e'(~mode_q) : mode_q;
      end
   end

   npc_pend_reg #(.AW(AW)) pend_i (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .load_i  (take_jump),
      .clr_i   (consume),
      .tgt_i   (jump_tgt),
      .mode_i  (jump_mode),
      .link_i  (jal_i | jalx_i),
      .lmode_i (mode_q),
      .vld_o   (pend_vld),
      .tgt_o   (pend_tgt),
      .mode_o  (pend_mode),
      .link_o  (pend_link),
      .lmode_o (pend_lmode)
   );

   always_comb begin
      if (pend_vld) begin
         flow = FLOW_PEND;
      end else if (br_i && br_taken_i) begin
         flow = FLOW_BR;
      end else begin
         flow = FLOW_SEQ;
      end
      unique case (flow)
         FLOW_PEND: pc_next = pend_tgt;
         FLOW_BR:   pc_next = br_tgt_i;
         default:   pc_next = seq_addr;
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         pc_q   <= RVEC;
         mode_q <= ISA_W32;
      end else if (adv_i) begin
         pc_q <= pc_next;
         if (consume) begin
            mode_q <= pend_mode;
         end
      end
   end

   always_comb begin
      pc_o       = pc_q;
      isa16_o    = (mode_q == ISA_C16);
      link_we_o  = consume & pend_link;
      link_o     = {seq_addr[AW-1:1], pend_lmode};
      addr_err_o = (mode_q == ISA_W32) && (pc_q[1:0] != 2'b00);
   end

   // R10: event inputs are one-hot or idle (input contract)
   p_ev_onehot_r10: assert property (@(posedge clk_i) disable iff (rst_i)
      $onehot0({jal_i, jalx_i, jr_i, br_i}));

   // R3: a stall freezes the fetch address and the mode
   p_hold_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      !adv_i |=> $stable(pc_o) && $stable(isa16_o));

   // R4: a jump moves first to its delay slot, with a target parked
   p_slot_r4: assert property (@(posedge clk_i) disable iff (rst_i)
      take_jump |=> (pc_o == $past(seq_addr)) && pend_vld);

   // R6: the mode never changes while the delay slot is pending
   p_mode_slot_r6: assert property (@(posedge clk_i) disable iff (rst_i)
      take_jump |=> isa16_o == $past(isa16_o));

   // R7: compact-mode fetch addresses stay halfword aligned
   p_c16_align_r7: assert property (@(posedge clk_i) disable iff (rst_i)
      isa16_o |-> !pc_o[0]);

   // R8: a taken branch redirects at once and parks nothing
   p_br_r8: assert property (@(posedge clk_i) disable iff (rst_i)
      br_go |=> (pc_o == $past(br_tgt_i)) && !pend_vld);

   // R10: retiring a delay slot leaves nothing pending
   p_slot_done_r10: assert property (@(posedge clk_i) disable iff (rst_i)
      consume |=> !pend_vld);

   // R11: only a retiring delay slot of an absolute jump writes the link
   p_link_src_r11: assert property (@(posedge clk_i) disable iff (rst_i)
      link_we_o |-> adv_i && pend_vld);

endmodule

// File: tb/npc_seq_tb.sv
`timescale 1ns/1ps
module npc_seq_tb_top;

   logic        clk_i = 1'b0;
   logic        rst_i;
   logic        adv_i, len16_i, jal_i, jalx_i, jr_i, br_i, br_taken_i;
   logic [31:0] br_tgt_i, rs_i;
   logic [25:0] jtgt_i;
   logic [31:0] pc_o, link_o;
   logic        isa16_o, link_we_o, addr_err_o;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   bit          s_lwe;
   logic [31:0] s_link;

   always #2.5 clk_i = ~clk_i;

   npc_seq dut_i (
      .clk_i(clk_i), .rst_i(rst_i), .adv_i(adv_i), .len16_i(len16_i),
      .jal_i(jal_i), .jalx_i(jalx_i), .jr_i(jr_i), .br_i(br_i),
      .br_taken_i(br_taken_i), .br_tgt_i(br_tgt_i), .jtgt_i(jtgt_i),
      .rs_i(rs_i), .pc_o(pc_o), .isa16_o(isa16_o), .link_we_o(link_we_o),
      .link_o(link_o), .addr_err_o(addr_err_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic idle();
      adv_i = 0; len16_i = 0; jal_i = 0; jalx_i = 0; jr_i = 0;
      br_i = 0; br_taken_i = 0; br_tgt_i = '0; jtgt_i = '0; rs_i = '0;
   endtask

   // ev: 0 none, 1 jal, 2 jalx, 3 jr, 4 branch taken, 5 branch not taken
   task automatic step(input bit adv, input bit l16, input int ev,
                       input logic [25:0] jt, input logic [31:0] val);
      adv_i = adv; len16_i = l16;
      jal_i = (ev == 1); jalx_i = (ev == 2); jr_i = (ev == 3);
      br_i = (ev == 4) || (ev == 5); br_taken_i = (ev == 4);
      jtgt_i = jt; rs_i = val; br_tgt_i = val;
      #1;
      s_lwe = link_we_o; s_link = link_o;
      @(posedge clk_i);
      @(negedge clk_i);
      idle();
   endtask

   function automatic logic [31:0] jabs(input logic [31:0] slot, input logic [25:0] jt);
      return {slot[31:28], jt, 2'b00};
   endfunction

   task automatic t_reset();
      rst_i = 1; idle();
      repeat (3) @(negedge clk_i);
      chk("R1 pc", pc_o, 32'h0000_1000);
      chk("R1 mode", {31'd0, isa16_o}, 0);
      chk("R1 err", {31'd0, addr_err_o}, 0);
      chk("R1 lwe", {31'd0, link_we_o}, 0);
      rst_i = 0;
   endtask

   task automatic t_seq32();
      step(1, 0, 0, 0, 0);
      chk("R2 +4", pc_o, 32'h1004);
   endtask

   task automatic t_stall();
      step(0, 0, 1, 26'h155, 0);
      chk("R3 pc", pc_o, 32'h1004);
      chk("R3 lwe", {31'd0, s_lwe}, 0);
      step(1, 0, 0, 0, 0);
      chk("R3 no pending left", pc_o, 32'h1008);
   endtask

   task automatic t_jal();
      step(1, 0, 1, 26'h400, 0);
      chk("R4 slot", pc_o, 32'h100C);
      step(1, 0, 0, 0, 0);
      chk("R5 lwe", {31'd0, s_lwe}, 1);
      chk("R5 link", s_link, 32'h1010);
      chk("R4 target", pc_o, jabs(32'h100C, 26'h400));
      chk("R4 mode", {31'd0, isa16_o}, 0);
   endtask

   task automatic t_jalx();
      step(1, 0, 2, 26'h800, 0);
      chk("R6 mode in slot", {31'd0, isa16_o}, 0);
      step(1, 0, 0, 0, 0);
      chk("R6 link old mode", s_link, 32'h1008);
      chk("R6 target", pc_o, 32'h2000);
      chk("R6 mode swapped", {31'd0, isa16_o}, 1);
      step(1, 1, 0, 0, 0);
      chk("R2 +2", pc_o, 32'h2002);
      step(1, 1, 1, 26'h900, 0);
      chk("R4 slot16", pc_o, 32'h2004);
      step(1, 1, 0, 0, 0);
      chk("R5 link16", s_link, 32'h2007);
      chk("R5 target16", pc_o, 32'h2400);
   endtask

   task automatic t_jr();
      step(1, 1, 3, 0, 32'h2001);
      chk("R7 slot", pc_o, 32'h2402);
      step(1, 1, 0, 0, 0);
      chk("R11 jr no link", {31'd0, s_lwe}, 0);
      chk("R7 odd target", pc_o, 32'h2000);
      chk("R7 mode16", {31'd0, isa16_o}, 1);
      chk("R9 no err16", {31'd0, addr_err_o}, 0);
      step(1, 1, 3, 0, 32'h3002);
      step(1, 1, 0, 0, 0);
      chk("R7 target32", pc_o, 32'h3002);
      chk("R7 mode32", {31'd0, isa16_o}, 0);
      chk("R9 err", {31'd0, addr_err_o}, 1);
      step(1, 0, 3, 0, 32'h1FFF_FFFC);
      step(1, 0, 0, 0, 0);
      chk("R9 err clear", {31'd0, addr_err_o}, 0);
      step(1, 0, 1, 26'h3FF_FFFF, 0);
      chk("R4 slot crosses", pc_o, 32'h2000_0000);
      step(1, 0, 0, 0, 0);
      chk("R5 link cross", s_link, 32'h2000_0004);
      chk("R4 top bits of slot", pc_o, 32'h2FFF_FFFC);
   endtask

   task automatic t_branch();
      step(1, 0, 4, 0, 32'h5000);
      chk("R8 taken", pc_o, 32'h5000);
      chk("R11 br no link", {31'd0, s_lwe}, 0);
      step(1, 0, 5, 0, 32'h7000);
      chk("R8 not taken", pc_o, 32'h5004);
   endtask

   task automatic t_slot_jump();
      step(1, 0, 1, 26'h1800, 0);
      step(0, 0, 0, 0, 0);
      chk("R3 slot stall", pc_o, 32'h5008);
      chk("R3 slot stall lwe", {31'd0, s_lwe}, 0);
      step(1, 0, 1, 26'h2000, 0);
      chk("R10 link once", s_link, 32'h500C);
      chk("R10 first target", pc_o, 32'h6000);
      step(1, 0, 0, 0, 0);
      chk("R10 slot jump ignored", pc_o, 32'h6004);
      chk("R10 no second link", {31'd0, s_lwe}, 0);
   endtask

   initial begin
      idle();
      rst_i = 1;
      @(negedge clk_i);
      t_reset();
      t_seq32();
      t_stall();
      t_jal();
      t_jalx();
      t_jr();
      t_branch();
      t_slot_jump();
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(5.0 * 100000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule